// File: doc/BRIEF.md
# Trigger Time-Stamp LSB Inserter

This block sits at the end of the output path of a 12-bit sampled-data stream. It carries four output lanes: two channels, each with a normal word and a delayed-sample word. When time-stamping is enabled, every lane keeps its upper 11 bits of conversion data. Bit 0 of each lane is replaced by the state of an external trigger line. The trigger line may be asynchronous to the sample clock. The converter then acts as an 11-bit converter with a 1-bit trigger channel alongside it, and that channel has exactly the same latency as the data.

The trigger passes through a two-flop synchronizer. Each lane is delayed by a register line of the same depth, and a final output register is shared by data and trigger. A word presented at the inputs before clock edge k therefore appears at the outputs after edge k+2, together with the trigger level seen at edge k.

The enable comes from bit 3 of a 16-bit control word. A two-state mode controller samples it, with states PASS and STAMP. ARM is the transition PASS→STAMP, taken when the bit is 1. DISARM is the transition STAMP→PASS, taken when the bit is 0. The state selects the output format for whole words, so no word is ever partly stamped.

Top module: `trig_stamp_inserter`

## Requirements
- R1: On every lane, output bits 11:1 after clock edge k equal input bits 11:1 presented before edge k-2, whatever the mode and trigger.
- R2: Only bit 3 of `ctrl_word` controls the mode. The other 15 bits have no effect on any output.
- R3: If bit 3 of `ctrl_word` was 1 at edge k-1, output bit 0 after edge k equals the trigger level sampled at edge k-2. This is the same latency as the data.
- R4: If bit 3 of `ctrl_word` was 0 at edge k-1, output bit 0 after edge k equals input bit 0 from edge k-2, and the trigger has no effect.
- R5: While stamping, bit 0 is identical on all four lanes.
- R6: The mode controller takes ARM (PASS→STAMP) and DISARM (STAMP→PASS) on single edges. An enable that toggles every cycle gives output words that alternate between fully stamped and fully passed.
- R7: A synchronous active-high `rst` clears all pipeline registers and enters PASS. All outputs are 0 after a reset edge and after the two edges that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Control word; bit 3 enables stamping |
| trig_async | input | 1 | External trigger, asynchronous to clk |
| i_word | input | 12 | Channel I sample word |
| i_word_dly | input | 12 | Channel I delayed-sample word |
| q_word | input | 12 | Channel Q sample word |
| q_word_dly | input | 12 | Channel Q delayed-sample word |
| i_out | output | 12 | Channel I output word |
| i_out_dly | output | 12 | Channel I delayed output word |
| q_out | output | 12 | Channel Q output word |
| q_out_dly | output | 12 | Channel Q delayed output word |

## Verification
The assertions check on every cycle that the upper bits arrive with the fixed three-edge latency, and that bit 0 follows the trigger or the data as the mode two edges back selects. They also check that the lanes agree on bit 0 while stamping, and that outputs are clear right after reset. The bench's scenarios are needed for the rest. A full sweep of all 4096 data codes shows that the other control bits are ignored. The same sweep runs with the enable held, toggling each cycle and in slow runs, which shows clean ARM/DISARM boundaries. A reset in mid-stream shows the zeroed window after release.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
    localparam int unsigned WORD_W = 12;
    localparam int unsigned LANES  = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_PASS  = 1'b0,
        MODE_STAMP = 1'b1
    } mode_e;
endpackage

// File: rtl/tstamp_sync.sv
module tstamp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tstamp_delay.sv
module tstamp_delay #(
    parameter int unsigned W     = 12,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/tstamp_mode_ctl.sv
module tstamp_mode_ctl
    import tstamp_pkg::*;
#(
    parameter int unsigned CTRL_W = 16,
    parameter int unsigned EN_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              stamp_sel
);
    mode_e state_q, state_d;
    logic  en_bit;

    assign en_bit = ctrl_word[EN_BIT];

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_PASS;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ARM and DISARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_PASS:  if (en_bit)  state_d = MODE_STAMP;
            MODE_STAMP: if (!en_bit) state_d = MODE_PASS;
            default:    state_d = MODE_PASS;
        endcase
    end

    // outputs
    always_comb begin
        stamp_sel = 1'b0;
        unique case (state_q)
            MODE_PASS:  stamp_sel = 1'b0;
            MODE_STAMP: stamp_sel = 1'b1;
            default:    stamp_sel = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_stamp_inserter.sv
module trig_stamp_inserter
    import tstamp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CTRL_W      = 16,
    parameter int unsigned EN_BIT      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              trig_async,
    input  logic [11:0]       i_word,
    input  logic [11:0]       i_word_dly,
    input  logic [11:0]       q_word,
    input  logic [11:0]       q_word_dly,
    output logic [11:0]       i_out,
    output logic [11:0]       i_out_dly,
    output logic [11:0]       q_out,
    output logic [11:0]       q_out_dly
);
    localparam int unsigned LAT = SYNC_STAGES + 1;

    word_t lane_in  [LANES];
    word_t lane_dly [LANES];
    word_t lane_q   [LANES];
    logic  trig_s;
    logic  stamp_sel;

    assign lane_in[0] = i_word;
    assign lane_in[1] = i_word_dly;
    assign lane_in[2] = q_word;
    assign lane_in[3] = q_word_dly;

    tstamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (trig_async),
        .q       (trig_s)
    );

    tstamp_mode_ctl #(.CTRL_W(CTRL_W), .EN_BIT(EN_BIT)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .ctrl_word (ctrl_word),
        .stamp_sel (stamp_sel)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tstamp_delay #(.W(WORD_W), .DEPTH(SYNC_STAGES)) u_dly (
            .clk (clk),
            .rst (rst),
            .d   (lane_in[l]),
            .q   (lane_dly[l])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[l] <= '0;
            end else if (stamp_sel) begin
                lane_q[l] <= {lane_dly[l][WORD_W-1:1], trig_s};
            end else begin
                lane_q[l] <= lane_dly[l];
            end
        end
    end

    assign i_out     = lane_q[0];
    assign i_out_dly = lane_q[1];
    assign q_out     = lane_q[2];
    assign q_out_dly = lane_q[3];
endmodule

// File: rtl/tstamp_checker.sv
module tstamp_checker #(
    parameter int unsigned LAT    = 3,
    parameter int unsigned CTRL_W = 16,
    parameter int unsigned EN_BIT = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              trig_async,
    input logic [11:0]       i_word,
    input logic [11:0]       i_word_dly,
    input logic [11:0]       q_word,
    input logic [11:0]       q_word_dly,
    input logic [11:0]       i_out,
    input logic [11:0]       i_out_dly,
    input logic [11:0]       q_out,
    input logic [11:0]       q_out_dly
);
    logic [11:0] ins  [4];
    logic [11:0] outs [4];
    logic [7:0]  settle;
    logic        warm;
    logic [3:0]  lsbs;

    assign ins[0]  = i_word;
    assign ins[1]  = i_word_dly;
    assign ins[2]  = q_word;
    assign ins[3]  = q_word_dly;
    assign outs[0] = i_out;
    assign outs[1] = i_out_dly;
    assign outs[2] = q_out;
    assign outs[3] = q_out_dly;
    assign lsbs    = {q_out_dly[0], q_out[0], i_out_dly[0], i_out[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            settle <= '0;
        end else if (settle < 8'(LAT)) begin
            settle <= settle + 8'd1;
        end
    end

    assign warm = (settle >= 8'(LAT));

    for (genvar l = 0; l < 4; l++) begin : g_chk
        a_r1_upper_latency: assert property (@(posedge clk) disable iff (rst)
            warm |-> outs[l][11:1] == $past(ins[l][11:1], LAT));

        a_r3_lsb_trigger: assert property (@(posedge clk) disable iff (rst)
            (warm && $past(ctrl_word[EN_BIT], LAT-1)) |-> outs[l][0] == $past(trig_async, LAT));

        a_r4_lsb_data: assert property (@(posedge clk) disable iff (rst)
            (warm && !$past(ctrl_word[EN_BIT], LAT-1)) |-> outs[l][0] == $past(ins[l][0], LAT));
    end

    a_r5_lanes_agree: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(ctrl_word[EN_BIT], LAT-1)) |-> ($countones(lsbs) == 0 || $countones(lsbs) == 4));

    a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (i_out == 12'd0 && i_out_dly == 12'd0 && q_out == 12'd0 && q_out_dly == 12'd0));
endmodule

bind trig_stamp_inserter tstamp_checker #(
    .LAT    (SYNC_STAGES + 1),
    .CTRL_W (CTRL_W),
    .EN_BIT (EN_BIT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_word  (ctrl_word),
    .trig_async (trig_async),
    .i_word     (i_word),
    .i_word_dly (i_word_dly),
    .q_word     (q_word),
    .q_word_dly (q_word_dly),
    .i_out      (i_out),
    .i_out_dly  (i_out_dly),
    .q_out      (q_out),
    .q_out_dly  (q_out_dly)
);

// File: tb/trig_stamp_inserter_test.sv
module trig_stamp_inserter_test;
    localparam int NCYC   = 4104;
    localparam int RST_AT = 3000;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] ctrl_word;
    logic        trig_async;
    logic [11:0] i_word, i_word_dly, q_word, q_word_dly;
    logic [11:0] i_out, i_out_dly, q_out, q_out_dly;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    trig_stamp_inserter uut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_word  (ctrl_word),
        .trig_async (trig_async),
        .i_word     (i_word),
        .i_word_dly (i_word_dly),
        .q_word     (q_word),
        .q_word_dly (q_word_dly),
        .i_out      (i_out),
        .i_out_dly  (i_out_dly),
        .q_out      (q_out),
        .q_out_dly  (q_out_dly)
    );

    // stimulus as pure functions of the cycle index
    function automatic bit rst_at(int n);
        return (n < 3) || (n == RST_AT) || (n == RST_AT + 1);
    endfunction

    function automatic logic [11:0] code(int n);
        return 12'(n);
    endfunction

    function automatic logic [11:0] lane_val(int n, int l);
        logic [11:0] v;
        v = code(n);
        case (l)
            0:       return v;
            1:       return ~v;
            2:       return v ^ 12'hA5A;
            default: return {v[5:0], v[11:6]};
        endcase
    endfunction

    // R6: held off, held on, toggling every cycle, slow runs
    function automatic bit en_at(int n);
        logic [11:0] v;
        v = code(n);
        case (v[11:10])
            2'd0:    return 1'b0;
            2'd1:    return 1'b1;
            2'd2:    return v[0];
            default: return v[3];
        endcase
    endfunction

    function automatic bit trig_at(int n);
        logic [11:0] v;
        v = code(n);
        return v[2] ^ v[7];
    endfunction

    // R2: the other control bits carry noise
    function automatic logic [15:0] ctrl_at(int n);
        logic [15:0] c;
        c = {code(n), code(n)[3:0]} ^ 16'h6C35;
        c[3] = en_at(n);
        return c;
    endfunction

    task automatic check(string tag, int lane, logic [11:0] act, logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s lane %0d: actual %03h expected %03h", tag, lane, act, exp);
        end
    endtask

    // output observed after edge n
    task automatic check_cycle(int n);
        logic [11:0] act [4];
        act[0] = i_out; act[1] = i_out_dly; act[2] = q_out; act[3] = q_out_dly;
        for (int l = 0; l < 4; l++) begin
            if (rst_at(n) || n < 2 || rst_at(n-1) || rst_at(n-2)) begin
                check("R7", l, act[l], 12'd0);
            end else begin
                logic [11:0] d;
                d = lane_val(n-2, l);
                // R1: upper bits, three-edge latency
                check("R1", l, {act[l][11:1], 1'b0}, {d[11:1], 1'b0});
                if (en_at(n-1)) begin
                    // R3 / R5: every lane carries the same trigger bit
                    check("R3", l, {11'd0, act[l][0]}, {11'd0, trig_at(n-2)});
                end else begin
                    // R4: trigger ignored, data LSB passes
                    check("R4", l, {11'd0, act[l][0]}, {11'd0, d[0]});
                end
            end
        end
    endtask

    initial begin
        rst = 1'b1; ctrl_word = '0; trig_async = 1'b0;
        i_word = '0; i_word_dly = '0; q_word = '0; q_word_dly = '0;
        for (int n = 0; n < NCYC; n++) begin
            @(negedge clk);
            if (n > 0) check_cycle(n - 1);
            rst        = rst_at(n);
            ctrl_word  = ctrl_at(n);
            trig_async = trig_at(n);
            i_word     = lane_val(n, 0);
            i_word_dly = lane_val(n, 1);
            q_word     = lane_val(n, 2);
            q_word_dly = lane_val(n, 3);
        end
        @(negedge clk);
        check_cycle(NCYC - 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule